// File: doc/BRIEF.md
# Instruction Length Decoder and Operand Assembler

This block sits behind an instruction byte source and splits a raw byte stream into whole instructions of a small 8-bit instruction set. Bytes arrive one per cycle through a valid/ready handshake, starting on a known instruction boundary. The first byte of each instruction is looked up in an internal length table. The block then gathers the operand bytes that opcode needs and emits one record per instruction: the start address, an optional index prefix, the opcode, the total length, the operand value, and an illegal flag.

Operand bytes are combined with the first one in the low half. For the relative jump the block also works out the branch target, measured from the address that follows the two-byte instruction. A 16-bit address counter steps once for every accepted byte. A synchronous restart pulse reloads it from a start-address input and returns the sequencer to the opcode position. An opcode the table does not hold is flagged and reported as a short instruction. Decoding then resumes on the very next byte.

Top module: `instr_len_decoder`

## Requirements
- R1: After reset the next byte address is 0x0000, and no record is valid. A one-cycle `restart` loads the address from `start_addr` and makes the next accepted byte an opcode.
- R2: Opcodes 0x00, 0xC9 and every opcode from 0x40 to 0xBF give a legal record with length 1 and operand 0x0000.
- R3: Opcodes 0x3E and 0x18 give length 2. The operand is the following byte, zero-extended to 16 bits.
- R4: Opcodes 0xC3 and 0x21 give length 3. The operand is formed with the first following byte as bits 7:0 and the second as bits 15:8.
- R5: For opcode 0x18 without a prefix, `out_rel` is 1. `out_target` equals the instruction address plus 2 plus the sign-extended operand byte, modulo 65536. For every other record both are 0.
- R6: A prefix byte 0xDD or 0xFD is reported in `out_prefix`, with the next byte as `out_opcode`. After a prefix, opcodes 0x21 and 0x36 give length 4 with a two-byte low-first operand. Opcodes 0x7E and 0x77 give length 3 with the displacement byte zero-extended. Without a prefix, `out_prefix` is 0x00.
- R7: An unprefixed opcode outside R2 to R6 gives `out_illegal` = 1, length 1 and operand 0. The next byte is decoded as an opcode.
- R8: After a prefix, an opcode outside the indexed set of R6 gives `out_illegal` = 1, length 2 and operand 0. The next byte is decoded as an opcode.
- R9: Every record appears one cycle after its last byte is accepted, with `out_addr` equal to the address of its first byte. Each record's address is the previous record's address plus its length. Cycles with `in_valid` low do not change the decode.
- R10: `in_ready` is low during reset and during a `restart` cycle. A byte offered then is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Reload the address and restart decoding at an opcode |
| start_addr | input | 16 | Address loaded on restart |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte can be accepted this cycle |
| out_valid | output | 1 | One-cycle record strobe |
| out_addr | output | 16 | Address of the instruction's first byte |
| out_prefix | output | 8 | Index prefix byte, or 0x00 |
| out_opcode | output | 8 | Opcode byte |
| out_len | output | 3 | Instruction length in bytes, 1 to 4 |
| out_operand | output | 16 | Assembled operand, low byte first in the stream |
| out_illegal | output | 1 | Opcode not in the supported table |
| out_rel | output | 1 | Record is a relative jump |
| out_target | output | 16 | Resolved relative jump target |

## Verification
A directed stream of every supported form is fed without gaps. This separates the length classes, and it also shows whether operand bytes are swapped. Relative jumps are placed at 0xFFFE with offset +127 and at 0x0000 with offset -128, so the target wraps in both directions. Sign extension is therefore checked at both extremes. A long random stream follows, with random idle cycles and a bias towards prefixes and unsupported codes. It exposes resynchronisation errors after illegal opcodes and stalls that disturb the sequencer. Because addresses are checked as a chain, any byte consumed twice or lost shows up as a wrong address. This includes a byte offered during a restart cycle.

// File: rtl/ild_pkg.sv
package ild_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    ST_OPC  = 2'd0,
    ST_XOPC = 2'd1,
    ST_ARG  = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic       legal;
    logic       prefix;
    logic [1:0] n_arg;
  } len_info_t;
endpackage

// File: rtl/ild_len_table.sv
module ild_len_table
  import ild_pkg::*;
(
  input  byte_t     opc,
  input  logic      indexed,
  output len_info_t info
);
  always_comb begin
    info = '0;
    if (!indexed) begin
      if (opc inside {[8'h40:8'hBF]}) begin
        info.legal = 1'b1;
      end else begin
        case (opc)
          8'h00, 8'hC9: info.legal = 1'b1;
          8'h3E, 8'h18: begin info.legal = 1'b1; info.n_arg = 2'd1; end
          8'hC3, 8'h21: begin info.legal = 1'b1; info.n_arg = 2'd2; end
          8'hDD, 8'hFD: begin info.legal = 1'b1; info.prefix = 1'b1; end
          default:      info = '0;
        endcase
      end
    end else begin
      case (opc)
        8'h21, 8'h36: begin info.legal = 1'b1; info.n_arg = 2'd2; end
        8'h7E, 8'h77: begin info.legal = 1'b1; info.n_arg = 2'd1; end
        default:      info = '0;
      endcase
    end
  end
endmodule

// File: rtl/ild_seq.sv
module ild_seq
  import ild_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic                acc,
  input  byte_t               in_byte,
  output logic                emit,
  output logic [ADDR_W-1:0]   e_addr,
  output byte_t               e_pfx,
  output byte_t               e_opc,
  output logic [LEN_W-1:0]    e_len,
  output logic [2*BYTE_W-1:0] e_opnd,
  output logic                e_ill
);
  seq_st_e           st_q;
  logic [ADDR_W-1:0] addr_q, base_q;
  byte_t             pfx_q, opc_q, lo_q;
  logic [1:0]        left_q;
  logic              got_q;
  len_info_t         info;

  ild_len_table u_tab (
    .opc     (in_byte),
    .indexed (st_q == ST_XOPC),
    .info    (info)
  );

  always_comb begin
    emit   = 1'b0;
    e_addr = base_q;
    e_pfx  = pfx_q;
    e_opc  = opc_q;
    e_len  = 3'd1;
    e_opnd = '0;
    e_ill  = 1'b0;
    case (st_q)
      ST_OPC: begin
        emit   = acc && (!info.legal || (!info.prefix && info.n_arg == 2'd0));
        e_addr = addr_q;
        e_pfx  = '0;
        e_opc  = in_byte;
        e_ill  = !info.legal;
      end
      ST_XOPC: begin
        emit  = acc && !info.legal;
        e_opc = in_byte;
        e_len = 3'd2;
        e_ill = 1'b1;
      end
      ST_ARG: begin
        emit   = acc && (left_q == 2'd1);
        e_len  = ((pfx_q != '0) ? 3'd2 : 3'd1) + (got_q ? 3'd2 : 3'd1);
        e_opnd = got_q ? {in_byte, lo_q} : {{BYTE_W{1'b0}}, in_byte};
      end
      default: emit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_OPC;
      addr_q <= '0;
      base_q <= '0;
      pfx_q  <= '0;
      opc_q  <= '0;
      lo_q   <= '0;
      left_q <= '0;
      got_q  <= 1'b0;
    end else if (restart) begin
      st_q   <= ST_OPC;
      addr_q <= start_addr;
    end else if (acc) begin
      addr_q <= addr_q + 1'b1;
      case (st_q)
        ST_OPC: begin
          base_q <= addr_q;
          pfx_q  <= '0;
          opc_q  <= in_byte;
          got_q  <= 1'b0;
          left_q <= info.n_arg;
          if (info.legal && info.prefix) begin
            pfx_q <= in_byte;
            st_q  <= ST_XOPC;
          end else if (info.legal && info.n_arg != 2'd0) begin
            st_q <= ST_ARG;
          end
        end
        ST_XOPC: begin
          opc_q  <= in_byte;
          left_q <= info.n_arg;
          got_q  <= 1'b0;
          st_q   <= info.legal ? ST_ARG : ST_OPC;
        end
        ST_ARG: begin
          lo_q   <= in_byte;
          got_q  <= 1'b1;
          left_q <= left_q - 2'd1;
          if (left_q == 2'd1) st_q <= ST_OPC;
        end
        default: st_q <= ST_OPC;
      endcase
    end
  end

  assert_restart_load_R1: assert property (@(posedge clk) disable iff (rst)
    restart |=> (addr_q == $past(start_addr)));

  assert_addr_step_R9: assert property (@(posedge clk) disable iff (rst)
    (acc && !restart) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!acc && !restart) |=> ($stable(addr_q) && $stable(st_q)));
endmodule

// File: rtl/ild_target.sv
module ild_target
  import ild_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  byte_t             offs,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - BYTE_W;
  logic [ADDR_W-1:0] offs_ext;
  assign offs_ext = {{EXT_W{offs[BYTE_W-1]}}, offs};
  assign target   = base + ADDR_W'(2) + offs_ext;
endmodule

// File: rtl/instr_len_decoder.sv
module instr_len_decoder
  import ild_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_byte,
  output logic                in_ready,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [BYTE_W-1:0]   out_prefix,
  output logic [BYTE_W-1:0]   out_opcode,
  output logic [LEN_W-1:0]    out_len,
  output logic [2*BYTE_W-1:0] out_operand,
  output logic                out_illegal,
  output logic                out_rel,
  output logic [ADDR_W-1:0]   out_target
);
  localparam byte_t REL_OPC = 8'h18;

  logic                acc, emit, e_ill, is_rel;
  logic [ADDR_W-1:0]   e_addr, tgt;
  byte_t               e_pfx, e_opc;
  logic [LEN_W-1:0]    e_len;
  logic [2*BYTE_W-1:0] e_opnd;

  assign in_ready = !rst && !restart;
  assign acc      = in_valid && in_ready;

  ild_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .start_addr (start_addr),
    .acc        (acc),
    .in_byte    (in_byte),
    .emit       (emit),
    .e_addr     (e_addr),
    .e_pfx      (e_pfx),
    .e_opc      (e_opc),
    .e_len      (e_len),
    .e_opnd     (e_opnd),
    .e_ill      (e_ill)
  );

  ild_target #(.ADDR_W(ADDR_W)) u_tgt (
    .base   (e_addr),
    .offs   (e_opnd[BYTE_W-1:0]),
    .target (tgt)
  );

  assign is_rel = !e_ill && (e_pfx == '0) && (e_opc == REL_OPC);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_prefix  <= '0;
      out_opcode  <= '0;
      out_len     <= '0;
      out_operand <= '0;
      out_illegal <= 1'b0;
      out_rel     <= 1'b0;
      out_target  <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_addr    <= e_addr;
        out_prefix  <= e_pfx;
        out_opcode  <= e_opc;
        out_len     <= e_len;
        out_operand <= e_opnd;
        out_illegal <= e_ill;
        out_rel     <= is_rel;
        out_target  <= is_rel ? tgt : '0;
      end
    end
  end

  assert_len_range_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd4));

  assert_block_single_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_prefix == '0 && out_opcode inside {[8'h40:8'hBF]})
      |-> (out_len == 3'd1 && !out_illegal));

  assert_short_operand_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal && out_prefix == '0 && out_len == 3'd2)
      |-> (out_operand[15:8] == 8'h00));

  assert_illegal_plain_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal && out_prefix == '0) |-> (out_len == 3'd1));

  assert_illegal_indexed_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal && out_prefix != '0) |-> (out_len == 3'd2));

  assert_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    restart |=> !out_valid);
endmodule

// File: tb/sim_instr_len_decoder.sv
`timescale 1ns/1ps
module sim_instr_len_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        restart = 1'b0;
  logic [15:0] start_addr = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_ready, out_valid, out_illegal, out_rel;
  logic [15:0] out_addr, out_operand, out_target;
  logic [7:0]  out_prefix, out_opcode;
  logic [2:0]  out_len;

  always #2 clk = ~clk;

  instr_len_decoder u0 (
    .clk(clk), .rst(rst), .restart(restart), .start_addr(start_addr),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_addr(out_addr), .out_prefix(out_prefix),
    .out_opcode(out_opcode), .out_len(out_len), .out_operand(out_operand),
    .out_illegal(out_illegal), .out_rel(out_rel), .out_target(out_target)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0]  stream [0:4095];
  int          ns = 0;
  logic [15:0] e_addr [0:2047];
  logic [7:0]  e_pfx  [0:2047];
  logic [7:0]  e_op   [0:2047];
  logic [2:0]  e_len  [0:2047];
  logic [15:0] e_opnd [0:2047];
  logic        e_ill  [0:2047];
  logic        e_rel  [0:2047];
  logic [15:0] e_tgt  [0:2047];
  string       e_tag  [0:2047];
  string       e_atag [0:2047];
  int          ne = 0, ri = 0;
  logic [15:0] cur_addr = 16'h0000;
  bit          first_after_restart = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Requirement model: operand byte count, -1 unsupported, -2 prefix
  function automatic int plain_args(input logic [7:0] op);
    if (op >= 8'h40 && op <= 8'hBF) return 0;
    case (op)
      8'h00, 8'hC9: return 0;
      8'h3E, 8'h18: return 1;
      8'hC3, 8'h21: return 2;
      8'hDD, 8'hFD: return -2;
      default:      return -1;
    endcase
  endfunction

  function automatic int idx_args(input logic [7:0] op);
    case (op)
      8'h21, 8'h36: return 2;
      8'h7E, 8'h77: return 1;
      default:      return -1;
    endcase
  endfunction

  task automatic push(input logic [7:0] b);
    stream[ns] = b;
    ns++;
  endtask

  task automatic rec(input logic [7:0] p, input logic [7:0] op, input int len,
                     input logic [15:0] opnd, input logic ill, input logic rel,
                     input logic [15:0] tgt, input string tag);
    e_addr[ne] = cur_addr; e_pfx[ne] = p; e_op[ne] = op; e_len[ne] = 3'(len);
    e_opnd[ne] = opnd; e_ill[ne] = ill; e_rel[ne] = rel; e_tgt[ne] = tgt;
    e_tag[ne] = tag;
    e_atag[ne] = first_after_restart ? "R1" : "R9";
    first_after_restart = 0;
    ne++;
    cur_addr = cur_addr + 16'(len);
  endtask

  task automatic add_instr(input logic [7:0] a0, input logic [7:0] a1,
                           input logic [7:0] a2, input logic [7:0] a3);
    int n0, n1;
    n0 = plain_args(a0);
    if (n0 == -1) begin
      push(a0);
      rec(8'h00, a0, 1, 16'h0, 1'b1, 1'b0, 16'h0, "R7");
    end else if (n0 == -2) begin
      n1 = idx_args(a1);
      push(a0); push(a1);
      if (n1 == -1) rec(a0, a1, 2, 16'h0, 1'b1, 1'b0, 16'h0, "R8");
      else begin
        push(a2);
        if (n1 == 2) push(a3);
        rec(a0, a1, 2 + n1, (n1 == 2) ? {a3, a2} : {8'h00, a2}, 1'b0, 1'b0,
            16'h0, "R6");
      end
    end else begin
      push(a0);
      if (n0 >= 1) push(a1);
      if (n0 == 2) push(a2);
      if (a0 == 8'h18)
        rec(8'h00, a0, 2, {8'h00, a1}, 1'b0, 1'b1,
            cur_addr + 16'd2 + {{8{a1[7]}}, a1}, "R5");
      else
        rec(8'h00, a0, 1 + n0,
            (n0 == 2) ? {a2, a1} : (n0 == 1) ? {8'h00, a1} : 16'h0,
            1'b0, 1'b0, 16'h0, (n0 == 2) ? "R4" : (n0 == 1) ? "R3" : "R2");
    end
  endtask

  task automatic feed(input int from, input bit gaps);
    int i = from;
    while (i < ns) begin
      @(negedge clk);
      if (gaps && ($urandom % 4 == 0)) in_valid = 1'b0;
      else begin
        in_valid = 1'b1;
        in_byte  = stream[i];
        i++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h00;
  endtask

  task automatic drain;
    repeat (8) @(negedge clk);
    chk(ri == ne, "R9", "record count", 32'(ri), 32'(ne));
  endtask

  task automatic do_restart(input logic [15:0] a);
    @(negedge clk);
    restart    = 1'b1;
    start_addr = a;
    in_valid   = 1'b1;
    in_byte    = 8'hC3;   // must not be consumed
    #1 chk(in_ready == 1'b0, "R10", "ready during restart", 32'(in_ready), 0);
    @(negedge clk);
    restart  = 1'b0;
    in_valid = 1'b0;
    cur_addr = a;
    first_after_restart = 1;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (ri >= ne) begin
        chk(1'b0, "R9", "unexpected record", 32'(out_addr), 0);
      end else begin
        chk(out_addr == e_addr[ri], e_atag[ri], "address", 32'(out_addr), 32'(e_addr[ri]));
        chk(out_len == e_len[ri], e_tag[ri], "length", 32'(out_len), 32'(e_len[ri]));
        chk(out_opcode == e_op[ri], e_tag[ri], "opcode", 32'(out_opcode), 32'(e_op[ri]));
        chk(out_prefix == e_pfx[ri], e_tag[ri], "prefix", 32'(out_prefix), 32'(e_pfx[ri]));
        chk(out_operand == e_opnd[ri], e_tag[ri], "operand", 32'(out_operand), 32'(e_opnd[ri]));
        chk(out_illegal == e_ill[ri], e_tag[ri], "illegal", 32'(out_illegal), 32'(e_ill[ri]));
        chk(out_rel == e_rel[ri], "R5", "rel flag", 32'(out_rel), 32'(e_rel[ri]));
        chk(out_target == e_tgt[ri], "R5", "target", 32'(out_target), 32'(e_tgt[ri]));
      end
      ri++;
    end
  end

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] a0, a1;
    logic [7:0] pick6 [0:5];
    logic [7:0] pick4 [0:3];
    int sel;
    int start;
    void'($urandom(32'h1CE5EED));
    pick6[0] = 8'h00; pick6[1] = 8'hC9; pick6[2] = 8'h3E;
    pick6[3] = 8'h18; pick6[4] = 8'hC3; pick6[5] = 8'h21;
    pick4[0] = 8'h21; pick4[1] = 8'h36; pick4[2] = 8'h7E; pick4[3] = 8'h77;

    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R10", "ready in reset", 32'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid after reset", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R10", "ready after reset", 32'(in_ready), 1);

    // R1 R2 R3 R4: directed forms from address zero, no gaps
    first_after_restart = 1;
    start = ns;
    add_instr(8'h00, 0, 0, 0);
    add_instr(8'hC9, 0, 0, 0);
    add_instr(8'h78, 0, 0, 0);
    add_instr(8'h40, 0, 0, 0);
    add_instr(8'hBF, 0, 0, 0);
    add_instr(8'h3E, 8'h5A, 0, 0);
    add_instr(8'hC3, 8'h34, 8'h12, 0);
    add_instr(8'h21, 8'hCD, 8'hAB, 0);
    feed(start, 0);
    drain();

    // R5 R6 R7 R8 R10: wrap targets, prefixes, unsupported codes, with stalls
    do_restart(16'hFFFE);
    start = ns;
    add_instr(8'h18, 8'h7F, 0, 0);      // target 0x007F
    add_instr(8'h18, 8'h80, 0, 0);      // from 0x0000, target 0xFF82
    add_instr(8'hDD, 8'h36, 8'h05, 8'hAA);
    add_instr(8'hFD, 8'h21, 8'h11, 8'h22);
    add_instr(8'hDD, 8'h7E, 8'hF0, 0);
    add_instr(8'hFD, 8'h77, 8'h01, 0);
    add_instr(8'hDD, 8'h00, 0, 0);
    add_instr(8'hED, 0, 0, 0);
    add_instr(8'h3F, 0, 0, 0);
    add_instr(8'h00, 0, 0, 0);
    feed(start, 1);
    drain();

    // Random stream, biased towards prefixes and unsupported codes
    do_restart(16'h1234);
    start = ns;
    for (int k = 0; k < 300; k++) begin
      sel = int'($urandom % 8);
      if (sel < 2)       a0 = 8'($urandom);
      else if (sel == 2) a0 = ($urandom % 2 == 0) ? 8'hDD : 8'hFD;
      else if (sel == 3) a0 = 8'h40 + 8'($urandom % 128);
      else               a0 = pick6[$urandom % 6];
      a1 = ($urandom % 2 == 0) ? pick4[$urandom % 4] : 8'($urandom);
      add_instr(a0, a1, 8'($urandom), 8'($urandom));
    end
    feed(start, 1);
    drain();

    summary();
    $finish;
  end
endmodule